// File: doc/BRIEF.md
# Page-Splitting DMA Descriptor Generator

This block turns one transfer request (a start address, a byte length and a direction) into a chain of DMA descriptors. No descriptor crosses a page boundary. A request whose start address lies inside a page first gets a short head fragment that ends at the next boundary. Whole pages follow, and then a closing fragment of at most one page. A stop descriptor always ends the chain. The address is used exactly as given; no translation takes place.

Descriptors leave one per cycle on a valid/ready stream that honours backpressure. With each accepted request the block also latches the 16-bit transfer-count value for the controller. It raises a one-cycle `done` after the stop descriptor has been taken. A request that is too long is refused with a one-cycle error flag and produces no descriptors.

Top module: `dma_page_splitter`

## Requirements
- R1: When the start address is not a multiple of PAGE_BYTES and the length exceeds the bytes left in that page, the first descriptor covers only those bytes. Its address is the start address. No data descriptor ever has (address mod PAGE_BYTES) + count > PAGE_BYTES.
- R2: After any head fragment, each descriptor has count PAGE_BYTES and a page-aligned address while the remaining length is strictly greater than PAGE_BYTES. Each descriptor's address is the previous address plus the previous count.
- R3: The descriptor that carries the final remaining bytes (at most one page) uses the "last" command. Every earlier data descriptor uses the "more" command.
- R4: Command codes on desc_cmd: output/more = 0, output/last = 1, input/more = 2, input/last = 3, stop = 7. req_dir = 1 selects the input codes and req_dir = 0 selects the output codes.
- R5: The last data descriptor is always followed by a stop descriptor (code 7) with count 0 and address 0. `done` is high for exactly one cycle, in the cycle after the stop descriptor is accepted.
- R6: A request with req_len > MAX_PAGES*PAGE_BYTES is accepted and then refused. req_err is high for one cycle after acceptance, and no descriptor appears.
- R7: desc_int, desc_wait and desc_branch are always 0, the "never" code.
- R8: From the cycle after a request is accepted, xfer_count equals req_len mod 65536. A 65536-byte request therefore gives 0.
- R9: While desc_valid is high and desc_ready is low, all descriptor outputs hold their values.
- R10: A zero-length request emits one descriptor with the "last" command, count 0 and the start address, followed by the stop descriptor.
- R11: After reset, desc_valid, done and req_err are low and req_ready is high. req_ready is high only while no chain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | block idle, request can be taken |
| req_addr | input | ADDR_W | start address |
| req_len | input | LEN_W | length in bytes |
| req_dir | input | 1 | 1 = input (device to memory), 0 = output |
| req_err | output | 1 | one-cycle pulse, request refused as too long |
| xfer_count | output | 16 | transfer-count value for the controller |
| desc_valid | output | 1 | descriptor present |
| desc_ready | input | 1 | consumer takes descriptor |
| desc_cmd | output | 4 | command code |
| desc_count | output | CNT_W | byte count |
| desc_addr | output | ADDR_W | byte address |
| desc_int | output | 2 | interrupt control, always never |
| desc_wait | output | 2 | wait control, always never |
| desc_branch | output | 2 | branch control, always never |
| done | output | 1 | one-cycle pulse after stop descriptor accepted |

## Verification
The assertions assume that desc_ready is a plain input that may toggle at any time. They also assume that requests arrive only through the req_valid/req_ready handshake, so address and length are sampled once and never change mid-chain. The bench keeps to this. It raises req_valid only when it wants a new chain and drops it in the cycle after acceptance. It drives desc_ready from a pseudo-random sequence so that stalls fall on head, middle, last and stop descriptors. The sweep crosses start offsets at 0, 1, mid-page and the last byte of a page with lengths around one page, many pages, 64 KiB, the maximum and just above it.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int CMD_W = 4;
  localparam int CTL_W = 2;

  localparam logic [CMD_W-1:0] CMD_OUT_MORE = 4'd0;
  localparam logic [CMD_W-1:0] CMD_OUT_LAST = 4'd1;
  localparam logic [CMD_W-1:0] CMD_IN_MORE  = 4'd2;
  localparam logic [CMD_W-1:0] CMD_IN_LAST  = 4'd3;
  localparam logic [CMD_W-1:0] CMD_STOP     = 4'd7;

  localparam logic [CTL_W-1:0] CTL_NEVER = 2'd0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_STOP  = 2'd2,
    ST_DRAIN = 2'd3
  } dps_state_e;

  function automatic logic [CMD_W-1:0] data_cmd(input logic dir_in, input logic last);
    return {2'b00, dir_in, last};
  endfunction
endpackage

// File: rtl/dps_frag_calc.sv
module dps_frag_calc #(
  parameter int PAGE_BYTES = 4096,
  parameter int LEN_W      = 18,
  localparam int PG_BITS   = $clog2(PAGE_BYTES)
) (
  input  logic [PG_BITS-1:0] page_off,
  input  logic [LEN_W-1:0]   remain,
  output logic [LEN_W-1:0]   frag,
  output logic               is_last
);
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

  logic [LEN_W-1:0] to_boundary;
  logic             head_cut;
  logic             over_page;

  always_comb begin
    to_boundary = PAGE_L - LEN_W'(page_off);
    head_cut    = (page_off != '0) && (remain > to_boundary);
    over_page   = remain > PAGE_L;
    if (head_cut) begin
      frag    = to_boundary;
      is_last = 1'b0;
    end else if (over_page) begin
      frag    = PAGE_L;
      is_last = 1'b0;
    end else begin
      frag    = remain;
      is_last = 1'b1;
    end
  end
endmodule

// File: rtl/dps_out_stage.sv
module dps_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 18,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_PAGES  = 32,
  localparam int PG_BITS   = $clog2(PAGE_BYTES),
  localparam int CNT_W     = PG_BITS + 1,
  localparam int XC_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic                     req_dir,
  output logic                     req_err,
  output logic [XC_W-1:0]          xfer_count,
  output logic                     desc_valid,
  input  logic                     desc_ready,
  output logic [dps_pkg::CMD_W-1:0] desc_cmd,
  output logic [CNT_W-1:0]         desc_count,
  output logic [ADDR_W-1:0]        desc_addr,
  output logic [dps_pkg::CTL_W-1:0] desc_int,
  output logic [dps_pkg::CTL_W-1:0] desc_wait,
  output logic [dps_pkg::CTL_W-1:0] desc_branch,
  output logic                     done
);
  import dps_pkg::*;

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PAGES * PAGE_BYTES);
  localparam int DW = CMD_W + CNT_W + ADDR_W;

  dps_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              dir_q;

  logic [LEN_W-1:0]  frag;
  logic              frag_last;
  logic              slot_free;
  logic              load;
  logic [DW-1:0]     load_word;
  logic [DW-1:0]     out_word;

  dps_frag_calc #(
    .PAGE_BYTES(PAGE_BYTES),
    .LEN_W     (LEN_W)
  ) u_calc (
    .page_off(cur_addr[PG_BITS-1:0]),
    .remain  (remain),
    .frag    (frag),
    .is_last (frag_last)
  );

  assign slot_free = !desc_valid || desc_ready;
  assign load      = ((state == ST_DATA) || (state == ST_STOP)) && slot_free;
  assign req_ready = (state == ST_IDLE);

  always_comb begin
    if (state == ST_DATA)
      load_word = {data_cmd(dir_q, frag_last), CNT_W'(frag), cur_addr};
    else
      load_word = {CMD_STOP, {CNT_W{1'b0}}, {ADDR_W{1'b0}}};
  end

  dps_out_stage #(.W(DW)) u_out (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (load_word),
    .ready(desc_ready),
    .valid(desc_valid),
    .q    (out_word)
  );

  assign desc_cmd    = out_word[DW-1 -: CMD_W];
  assign desc_count  = out_word[ADDR_W +: CNT_W];
  assign desc_addr   = out_word[ADDR_W-1:0];
  assign desc_int    = CTL_NEVER;
  assign desc_wait   = CTL_NEVER;
  assign desc_branch = CTL_NEVER;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      dir_q      <= 1'b0;
      xfer_count <= '0;
      req_err    <= 1'b0;
      done       <= 1'b0;
    end else begin
      req_err <= 1'b0;
      done    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_len > MAX_LEN) begin
              req_err <= 1'b1;
            end else begin
              cur_addr   <= req_addr;
              remain     <= req_len;
              dir_q      <= req_dir;
              xfer_count <= XC_W'(req_len);
              state      <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (slot_free) begin
            cur_addr <= cur_addr + ADDR_W'(frag);
            remain   <= remain - frag;
            if (frag_last) state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (slot_free) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (desc_valid && desc_ready) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  localparam int PG_BITS   = $clog2(PAGE_BYTES),
  localparam int CNT_W     = PG_BITS + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              req_err,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [3:0]        desc_cmd,
  input logic [CNT_W-1:0]  desc_count,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [1:0]        desc_int,
  input logic [1:0]        desc_wait,
  input logic [1:0]        desc_branch,
  input logic              done
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_cmd) && $stable(desc_count) && $stable(desc_addr)); // R9

  AST_CTL_NEVER: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_int == 2'd0) && (desc_wait == 2'd0) && (desc_branch == 2'd0)); // R7

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    desc_valid && (desc_cmd == 4'd7) |-> (desc_count == '0) && (desc_addr == '0)); // R5

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
    desc_valid && (desc_cmd != 4'd7) |->
      (32'(desc_addr[PG_BITS-1:0]) + 32'(desc_count)) <= 32'(PAGE_BYTES)); // R1

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_cmd <= 4'd3) || (desc_cmd == 4'd7)); // R4

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(desc_valid && desc_ready && (desc_cmd == 4'd7))); // R5

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_err |-> !desc_valid && req_ready); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> !req_ready); // R11
endmodule

bind dma_page_splitter dps_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES)
) u_dps_checker (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .req_err    (req_err),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .desc_cmd   (desc_cmd),
  .desc_count (desc_count),
  .desc_addr  (desc_addr),
  .desc_int   (desc_int),
  .desc_wait  (desc_wait),
  .desc_branch(desc_branch),
  .done       (done)
);

// File: tb/tb_dma_page_splitter.sv
module tb_dma_page_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 18;
  localparam int PAGE       = 4096;
  localparam int MAXP       = 32;
  localparam int CNT_W      = $clog2(PAGE) + 1;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_dir = 1'b0;
  logic              req_err;
  logic [15:0]       xfer_count;
  logic              desc_valid;
  logic              desc_ready = 1'b0;
  logic [3:0]        desc_cmd;
  logic [CNT_W-1:0]  desc_count;
  logic [ADDR_W-1:0] desc_addr;
  logic [1:0]        desc_int, desc_wait, desc_branch;
  logic              done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_splitter #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .MAX_PAGES(MAXP)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_dir(req_dir), .req_err(req_err),
    .xfer_count(xfer_count), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_cmd(desc_cmd), .desc_count(desc_count), .desc_addr(desc_addr),
    .desc_int(desc_int), .desc_wait(desc_wait), .desc_branch(desc_branch),
    .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic run_req(input longint addr, input longint len, input bit dir);
    longint eaddr = addr;
    longint erem  = len;
    bit     stop_seen = 0;
    bit     data_done = 0;
    bit     first = 1;
    bit     held = 0;
    logic [3:0] h_cmd;
    logic [CNT_W-1:0] h_cnt;
    logic [ADDR_W-1:0] h_addr;
    longint off, ecnt;
    bit     elast;
    @(negedge clk);
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    req_dir   = dir;
    req_valid = 1'b1;
    check(req_ready == 1'b1, "R11 ready before request", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (len > MAXP * PAGE) begin
      check(req_err == 1'b1, "R6 error pulse", req_err, 1);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check(desc_valid == 1'b0, "R6 no descriptor", desc_valid, 0);
        check(req_err == 1'b0, "R6 pulse one cycle", req_err, 0);
      end
      return;
    end
    check(req_err == 1'b0, "R6 no error", req_err, 0);
    check(xfer_count == 16'(len % 65536), "R8 transfer count", xfer_count, len % 65536);
    check(req_ready == 1'b0, "R11 busy", req_ready, 0);
    while (!stop_seen) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      desc_ready = lfsr[0] | lfsr[1];
      if (held) begin
        check(desc_valid && desc_cmd == h_cmd && desc_count == h_cnt && desc_addr == h_addr,
              "R9 hold under stall", desc_addr, h_addr);
      end
      if (desc_valid) begin
        check(desc_int == 0 && desc_wait == 0 && desc_branch == 0, "R7 control fields",
              {desc_int, desc_wait, desc_branch}, 0);
      end
      if (desc_valid && desc_ready) begin
        if (!data_done) begin
          off = eaddr % PAGE;
          if (off != 0 && erem > PAGE - off) begin
            ecnt = PAGE - off; elast = 0;
            check(first, "R1 head only first", 0, 1);
          end else if (erem > PAGE) begin
            ecnt = PAGE; elast = 0;
            check(off == 0, "R2 page aligned", off, 0);
          end else begin
            ecnt = erem; elast = 1;
          end
          if (len == 0)
            check(desc_count == 0 && desc_addr == ADDR_W'(addr), "R10 zero length", desc_count, 0);
          check(desc_count == CNT_W'(ecnt), first ? "R1 count" : "R2 count", desc_count, ecnt);
          check(desc_addr == ADDR_W'(eaddr), "R2 address", desc_addr, eaddr);
          check(desc_cmd == {2'b00, dir, elast}, elast ? "R3 last cmd" : "R4 more cmd",
                desc_cmd, {dir, elast});
          eaddr += ecnt;
          erem  -= ecnt;
          first = 0;
          if (elast) data_done = 1;
        end else begin
          check(desc_cmd == 4'd7 && desc_count == 0 && desc_addr == 0, "R5 stop descriptor",
                desc_cmd, 7);
          stop_seen = 1;
        end
      end
      held   = desc_valid && !desc_ready;
      h_cmd  = desc_cmd;
      h_cnt  = desc_count;
      h_addr = desc_addr;
      @(negedge clk);
      if (!stop_seen) check(done == 1'b0, "R5 no early done", done, 0);
    end
    check(done == 1'b1, "R5 done pulse", done, 1);
    desc_ready = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", done, 0);
    check(desc_valid == 1'b0, "R5 nothing after stop", desc_valid, 0);
    check(req_ready == 1'b1, "R11 idle again", req_ready, 1);
  endtask

  initial begin
    longint offs [4] = '{0, 1, 2048, 4095};
    longint lens [14] = '{0, 1, 100, 4095, 4096, 4097, 8191, 8192, 12289,
                          65536, 131071, 131072, 131073, 200000};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(desc_valid == 1'b0, "R11 reset valid", desc_valid, 0);
    check(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    check(done == 1'b0 && req_err == 1'b0, "R11 reset pulses", {done, req_err}, 0);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 14; j++) begin
        run_req(32'h0001_0000 + offs[i], lens[j], 1'((i + j) % 2));
      end
    end
    run_req(32'h0000_7F00, 200, 1'b1);
    finish_run();
  end
endmodule